// File: doc/BRIEF.md
# Tape Motion Phase Sequencer

This block steps one tape command through the motion phases of a transport: idle, waiting for the channel, starting, traversing an erase gap, transferring data, stopping, and error. A single down-counter times every phase. It counts an external microsecond tick and is loaded on each phase entry with a delay built from a set of timing inputs. There are two such sets, real and fast, and the `fast` input selects one of them when a command is accepted. The start delay depends on the command kind, on whether the tape sits at load point, and on whether tape motion can carry on from the previous command.

During the data phase the block paces word transfers against the channel. A single data flag serves both directions. On a read, each data step hands a word to the channel and clears the flag, and the channel strobe sets it again. On a write, the channel strobe deposits a word and sets the flag, and each data step consumes the word and clears the flag. A data step that finds the flag still clear is a timing error. On a read this is an overrun and the record runs to its end. On a write this is an underrun and it fails the command. In fast mode the next data step is only scheduled once the channel strobe arrives, so timing errors cannot occur.

Top module: `tape_phase_seq`

## Requirements
- R1: After reset, `phase` is 0 (idle) and `svc_req`, `word_stb`, `timing_err`, `eod`, `done` and `fail` are low. The `phase` output encodes idle=0, wait=1, start=2, traverse=3, data=4, stop=5, error=6.
- R2: A phase loaded with delay D leaves only after the counter reaches zero. With `tick` high on every clock, the phase lasts D+1 clocks. The start phase is loaded with `ovh` alone for a select or a continued command, `ovh+bot` when `at_bot` is high, and `ovh+irg` otherwise.
- R3: A write accepted with `gap_req` high goes from start to traverse for `gap_len*byte`, then to data after `2*byte`. Every other transfer command goes from start to data after `2*byte`.
- R4: Each data step pulses `word_stb` once. Consecutive steps are `2*byte` apart in real mode, and a transfer command of length L (L≥1) produces L pulses.
- R5: After the last word, the stop phase lasts `irg`, and then `done` pulses. A `chan_end` during a read data phase, with k words moved, goes to stop with delay `(L-k)*byte+irg` and raises `eod`.
- R6: On a read, the flag starts set, each data step clears it and raises `svc_req`, and a strobe while `svc_req` is high sets it and drops `svc_req`. A data step that finds the flag clear raises `timing_err`, and the record still completes without `fail`.
- R7: A write raises `svc_req` when accepted. If a write data step finds no word deposited, `timing_err` and `fail` rise and the machine enters the error phase with no `word_stb`.
- R8: In fast mode, after a data step the counter holds until a channel strobe arrives, so no further `word_stb` occurs without one and `timing_err` never rises.
- R9: `fault` in any active phase other than error enters error for `irg`. The machine then returns to idle with a one-clock `done` pulse and `fail` high.
- R10: Opcodes 0 (read forward) and 3 (space forward) form one group, 1 (read reverse) and 4 (space reverse) a second, and 2 (write) a third. A command of the same group accepted within CHAIN ticks of a successful `done` uses a start delay of `ovh` only.
- R11: `abort` in any active phase moves to stop with zero delay, so `done` pulses on the following clock.
- R12: Space commands (3, 4) take `L*byte` in data and then `irg` in stop, with no `word_stb`. Rewind (5) goes from start to stop for `rew`. Select (6) goes from start to stop with zero delay.
- R13: A transfer command (0, 1, 2) accepted while `chan_go` is low waits in phase 1 until `chan_go` rises, and only then starts its start delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer decrement enable (1 us) |
| cmd_valid | input | 1 | Command accept strobe, sampled in idle |
| cmd_op | input | 3 | Command opcode |
| cmd_len | input | LW | Record length in words |
| at_bot | input | 1 | Tape at load point |
| gap_req | input | 1 | Write needs an initial erase gap |
| gap_len | input | GW | Gap length in byte times |
| fast | input | 1 | Select fast timing set |
| chan_go | input | 1 | Channel ready to start transfer |
| chan_stb | input | 1 | Channel data strobe |
| chan_end | input | 1 | Channel transfer count exhausted |
| abort | input | 1 | Synchronous abort |
| fault | input | 1 | Drive failure |
| r_ovh | input | TW | Real controller overhead |
| r_bot | input | TW | Real load-point start time |
| r_irg | input | TW | Real inter-record time |
| r_byte | input | TW | Real byte time |
| r_rew | input | TW | Real rewind time |
| f_ovh | input | TW | Fast controller overhead |
| f_bot | input | TW | Fast load-point start time |
| f_irg | input | TW | Fast inter-record time |
| f_byte | input | TW | Fast byte time |
| f_rew | input | TW | Fast rewind time |
| phase | output | 3 | Current phase |
| svc_req | output | 1 | Channel service request |
| word_stb | output | 1 | Data step pulse |
| timing_err | output | 1 | Overrun or underrun seen |
| eod | output | 1 | Data transfer ended |
| done | output | 1 | Command complete pulse |
| fail | output | 1 | Command ended in error phase |

## Verification
The bench builds the block with CHAIN=30, LW=8 and GW=6. The short chain window lets it issue commands both inside and after the continuation window within a few dozen clocks, and the narrow length and gap fields keep every multiplied delay small. With `tick` held high, each delay maps to an exact clock count, so the bench predicts every `word_stb` and `done` edge. It covers random mixes of opcodes, load-point states and timing sets, and directed runs for overrun, underrun, early channel end, abort, fault, the wait phase and the fast-mode hold.

// File: rtl/tape_phase_seq.sv
module tape_phase_seq #(
  parameter int TW    = 24,
  parameter int LW    = 16,
  parameter int GW    = 8,
  parameter int CHAIN = 103
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [LW-1:0] cmd_len,
  input  logic          at_bot,
  input  logic          gap_req,
  input  logic [GW-1:0] gap_len,
  input  logic          fast,
  input  logic          chan_go,
  input  logic          chan_stb,
  input  logic          chan_end,
  input  logic          abort,
  input  logic          fault,
  input  logic [TW-1:0] r_ovh,
  input  logic [TW-1:0] r_bot,
  input  logic [TW-1:0] r_irg,
  input  logic [TW-1:0] r_byte,
  input  logic [TW-1:0] r_rew,
  input  logic [TW-1:0] f_ovh,
  input  logic [TW-1:0] f_bot,
  input  logic [TW-1:0] f_irg,
  input  logic [TW-1:0] f_byte,
  input  logic [TW-1:0] f_rew,
  output logic [2:0]    phase,
  output logic          svc_req,
  output logic          word_stb,
  output logic          timing_err,
  output logic          eod,
  output logic          done,
  output logic          fail
);
  localparam int CW = $clog2(CHAIN + 1);

  localparam logic [2:0] PH_IDLE = 3'd0, PH_WAIT = 3'd1, PH_START = 3'd2,
                         PH_TRAV = 3'd3, PH_DATA = 3'd4, PH_STOP  = 3'd5,
                         PH_ERR  = 3'd6;

  localparam logic [2:0] OP_RDF = 3'd0, OP_RDR = 3'd1, OP_WR  = 3'd2,
                         OP_SPF = 3'd3, OP_SPR = 3'd4, OP_REW = 3'd5,
                         OP_SEL = 3'd6;

  function automatic logic [1:0] grp_of(input logic [2:0] op);
    case (op)
      OP_RDF, OP_SPF: grp_of = 2'd1;
      OP_RDR, OP_SPR: grp_of = 2'd2;
      OP_WR:          grp_of = 2'd3;
      default:        grp_of = 2'd0;
    endcase
  endfunction

  logic [TW-1:0] cnt;
  logic [2:0]    op_q;
  logic [LW-1:0] len_q, idx;
  logic          flag, hold, fast_q, gap_q;
  logic [CW-1:0] chain_cnt;
  logic [1:0]    last_grp;

  wire          fs     = (phase == PH_IDLE) ? fast : fast_q;
  wire [TW-1:0] d_ovh  = fs ? f_ovh  : r_ovh;
  wire [TW-1:0] d_bot  = fs ? f_bot  : r_bot;
  wire [TW-1:0] d_irg  = fs ? f_irg  : r_irg;
  wire [TW-1:0] d_byte = fs ? f_byte : r_byte;
  wire [TW-1:0] d_rew  = fs ? f_rew  : r_rew;
  wire [TW-1:0] two_b  = {d_byte[TW-2:0], 1'b0};

  wire [2:0] op_c    = (phase == PH_IDLE) ? cmd_op : op_q;
  wire       chained = (chain_cnt != '0) && (grp_of(op_c) != 2'd0) &&
                       (grp_of(op_c) == last_grp);
  wire [TW-1:0] start_d = (op_c == OP_SEL || chained) ? d_ovh :
                          d_ovh + (at_bot ? d_bot : d_irg);

  wire [TW-1:0] gap_t  = d_byte * TW'(gap_len);
  wire [TW-1:0] len_t  = d_byte * TW'(len_q);
  wire [TW-1:0] rem_t  = d_byte * TW'(len_q - idx) + d_irg;

  wire xfer   = op_q <= OP_WR;
  wire rd     = (op_q == OP_RDF) || (op_q == OP_RDR);
  wire spc    = (op_q == OP_SPF) || (op_q == OP_SPR);
  wire stb_ok = chan_stb && svc_req;
  wire fl     = flag || stb_ok;
  wire expd   = (cnt == '0) && !hold;
  wire last   = (idx + 1'b1) == len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;  cnt <= '0;      op_q <= OP_RDF;
      len_q <= '0;       idx <= '0;      flag <= 1'b0;
      hold <= 1'b0;      fast_q <= 1'b0; gap_q <= 1'b0;
      chain_cnt <= '0;   last_grp <= 2'd0;
      svc_req <= 1'b0;   word_stb <= 1'b0; timing_err <= 1'b0;
      eod <= 1'b0;       done <= 1'b0;   fail <= 1'b0;
    end else begin
      word_stb <= 1'b0;
      done     <= 1'b0;
      if (tick && cnt != '0 && !hold) cnt <= cnt - 1'b1;
      if (tick && chain_cnt != '0) chain_cnt <= chain_cnt - 1'b1;
      if (stb_ok) begin
        flag    <= 1'b1;
        svc_req <= 1'b0;
        if (hold) begin
          hold <= 1'b0;
          cnt  <= two_b;
        end
      end

      case (phase)
        PH_IDLE: if (cmd_valid) begin
          op_q       <= cmd_op;
          len_q      <= cmd_len;
          gap_q      <= gap_req;
          fast_q     <= fast;
          idx        <= '0;
          hold       <= 1'b0;
          timing_err <= 1'b0;
          eod        <= 1'b0;
          fail       <= 1'b0;
          flag       <= (cmd_op == OP_RDF) || (cmd_op == OP_RDR);
          svc_req    <= cmd_op == OP_WR;
          if (cmd_op <= OP_WR && !chan_go) begin
            phase <= PH_WAIT;
          end else begin
            phase <= PH_START;
            cnt   <= start_d;
          end
        end
        PH_WAIT: if (chan_go) begin
          phase <= PH_START;
          cnt   <= start_d;
        end
        PH_START: if (expd) begin
          if (op_q == OP_SEL) begin
            phase <= PH_STOP; cnt <= '0;
          end else if (op_q == OP_REW) begin
            phase <= PH_STOP; cnt <= d_rew;
          end else if (op_q == OP_WR && gap_q) begin
            phase <= PH_TRAV; cnt <= gap_t;
          end else if (spc) begin
            phase <= PH_DATA; cnt <= len_t;
          end else begin
            phase <= PH_DATA; cnt <= two_b;
          end
        end
        PH_TRAV: if (expd) begin
          phase <= PH_DATA;
          cnt   <= two_b;
        end
        PH_DATA: begin
          if (chan_end && xfer) begin
            phase   <= PH_STOP;
            cnt     <= rd ? rem_t : d_irg;
            eod     <= 1'b1;
            svc_req <= 1'b0;
            hold    <= 1'b0;
          end else if (expd) begin
            if (spc) begin
              phase <= PH_STOP;
              cnt   <= d_irg;
            end else if (fast_q && !fl) begin
              hold <= 1'b1;
            end else if (!fl && !rd) begin
              timing_err <= 1'b1;
              fail       <= 1'b1;
              svc_req    <= 1'b0;
              phase      <= PH_ERR;
              cnt        <= d_irg;
            end else begin
              if (!fl) timing_err <= 1'b1;
              word_stb <= 1'b1;
              flag     <= 1'b0;
              idx      <= idx + 1'b1;
              svc_req  <= rd || !last;
              if (last) begin
                phase <= PH_STOP;
                cnt   <= d_irg;
                eod   <= 1'b1;
              end else begin
                cnt  <= two_b;
                hold <= fast_q;
              end
            end
          end
        end
        PH_STOP: if (expd) begin
          phase   <= PH_IDLE;
          done    <= 1'b1;
          svc_req <= 1'b0;
          if (!fail) begin
            chain_cnt <= CW'(CHAIN);
            last_grp  <= grp_of(op_q);
          end
        end
        PH_ERR: if (expd) begin
          phase   <= PH_IDLE;
          done    <= 1'b1;
          svc_req <= 1'b0;
        end
        default: phase <= PH_IDLE;
      endcase

      if (fault && phase != PH_IDLE && phase != PH_ERR) begin
        phase   <= PH_ERR;
        cnt     <= d_irg;
        fail    <= 1'b1;
        svc_req <= 1'b0;
        hold    <= 1'b0;
      end
      if (abort && phase != PH_IDLE) begin
        phase   <= PH_STOP;
        cnt     <= '0;
        svc_req <= 1'b0;
        hold    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tape_phase_seq_chk.sv
module tape_phase_seq_chk #(parameter int TW = 24) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    phase,
  input logic          word_stb,
  input logic          done,
  input logic          svc_req,
  input logic          timing_err,
  input logic          fast_q,
  input logic          abort,
  input logic          fault,
  input logic [TW-1:0] cnt
);
  // R4
  stb_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> $past(phase) == 3'd4);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> phase == 3'd0);
  // R11
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && phase != 3'd0) |=> phase == 3'd5);
  // R8
  fast_no_terr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timing_err) |-> !fast_q);
  // R2
  zero_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase) && ($past(phase) == 3'd2 || $past(phase) == 3'd3)
     && !$past(abort) && !$past(fault)) |-> $past(cnt) == '0);
  // R6
  idle_no_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0 && !$past(phase == 3'd0 && svc_req)) |-> !svc_req || $past(phase) == 3'd0);
endmodule

bind tape_phase_seq tape_phase_seq_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .word_stb(word_stb),
  .done(done), .svc_req(svc_req), .timing_err(timing_err),
  .fast_q(fast_q), .abort(abort), .fault(fault), .cnt(cnt));

// File: tb/tb_tape_phase_seq.sv
module tb_tape_phase_seq;
  localparam int TW = 24, LW = 8, GW = 6, CHAIN = 30;
  localparam int RO = 4, RB = 9, RI = 6, RY = 3, RR = 20, GL = 5;
  localparam int FO = 1, FB = 2, FI = 1, FY = 1, FR = 3;

  logic clk = 0, rst_n = 0, tick = 1, cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [LW-1:0] cmd_len = 1;
  logic at_bot = 0, gap_req = 0, fast = 0, chan_go = 1, chan_stb = 0;
  logic chan_end = 0, abort = 0, fault = 0;
  logic [2:0] phase;
  logic svc_req, word_stb, timing_err, eod, done, fail;

  always #10 clk = ~clk;

  tape_phase_seq #(.TW(TW), .LW(LW), .GW(GW), .CHAIN(CHAIN)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_len(cmd_len), .at_bot(at_bot), .gap_req(gap_req),
    .gap_len(GW'(GL)), .fast(fast), .chan_go(chan_go), .chan_stb(chan_stb),
    .chan_end(chan_end), .abort(abort), .fault(fault),
    .r_ovh(TW'(RO)), .r_bot(TW'(RB)), .r_irg(TW'(RI)), .r_byte(TW'(RY)), .r_rew(TW'(RR)),
    .f_ovh(TW'(FO)), .f_bot(TW'(FB)), .f_irg(TW'(FI)), .f_byte(TW'(FY)), .f_rew(TW'(FR)),
    .phase(phase), .svc_req(svc_req), .word_stb(word_stb), .timing_err(timing_err),
    .eod(eod), .done(done), .fail(fail));

  int checks = 0, failures = 0, cyc = 0;
  int lat = 1, w = 0;
  bit chan_en = 1;
  int last_done = -1000, last_grp = 0;
  bit last_ok = 0;
  int g_acc, g_first, g_last, g_cnt, g_done, g_kcyc, g_mask;
  bit g_terr, g_fail, g_eod, g_chained;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (chan_en && svc_req && !chan_stb) begin
      if (w >= lat) begin chan_stb = 1; w = 0; end
      else w = w + 1;
    end else begin
      chan_stb = 0;
      if (!svc_req) w = 0;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int grp(input int op);
    if (op == 0 || op == 3) return 1;
    if (op == 1 || op == 4) return 2;
    if (op == 2) return 3;
    return 0;
  endfunction

  function automatic int sdel(input int op, input int bot, input bit ch, input int f);
    int o = f ? FO : RO;
    if (op == 6 || ch) return o;
    return o + (bot ? (f ? FB : RB) : (f ? FI : RI));
  endfunction

  task automatic run(input int op, input int bot, input int gap, input int len,
                     input int f, input int lt, input bit en, input int endk,
                     input int abort_at, input int fault_at, input int go_at);
    bit ended = 0;
    @(negedge clk);
    cmd_op = 3'(op); at_bot = bot[0]; gap_req = gap[0]; cmd_len = LW'(len);
    fast = f[0]; lat = lt; chan_en = en; chan_go = (go_at == 0);
    cmd_valid = 1;
    g_acc = cyc + 1;
    g_chained = grp(op) != 0 && grp(op) == last_grp && last_ok &&
                (g_acc - last_done) <= CHAIN;
    g_cnt = 0; g_first = -1; g_last = -1; g_done = -1; g_kcyc = -1; g_mask = 0;
    @(negedge clk);
    cmd_valid = 0;
    for (int i = 0; i < 4000; i++) begin
      chan_end = 0; abort = 0; fault = 0;
      g_mask = g_mask | (1 << phase);
      if (word_stb) begin
        g_cnt++;
        if (g_first < 0) g_first = cyc;
        g_last = cyc;
        if (g_cnt == endk && !ended) begin chan_end = 1; ended = 1; g_kcyc = cyc; end
      end
      if (abort_at > 0 && cyc - g_acc == abort_at) abort = 1;
      if (fault_at > 0 && cyc - g_acc == fault_at) fault = 1;
      if (go_at > 0 && cyc - g_acc == go_at) chan_go = 1;
      if (done) begin
        g_done = cyc; g_terr = timing_err; g_fail = fail; g_eod = eod;
        break;
      end
      @(negedge clk);
    end
    chan_end = 0; abort = 0; fault = 0; chan_go = 1;
    if (g_done < 0) chk("R9 command never completed", 0, 1);
    last_done = g_done; last_grp = grp(op); last_ok = !g_fail;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s, b;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 phase", phase, 0); chk("R1 svc_req", svc_req, 0);
    chk("R1 word_stb", word_stb, 0); chk("R1 timing_err", timing_err, 0);
    chk("R1 eod", eod, 0); chk("R1 done", done, 0); chk("R1 fail", fail, 0);
    rst_n = 1;
    idle(2);

    // R2 R4 R5 plain read at BOT
    run(0, 1, 0, 4, 0, 1, 1, 0, 0, 0, 0);
    chk("R2 first word", g_first - g_acc, RO + RB + 1 + 2*RY + 1);
    chk("R4 word count", g_cnt, 4);
    chk("R4 word spacing", (g_last - g_first) / 3, 2*RY + 1);
    chk("R5 stop after last", g_done - g_last, RI + 1);
    chk("R5 eod", g_eod, 1);
    chk("R6 no overrun", g_terr, 0);

    // R10 chained read forward
    idle(2);
    run(3, 0, 0, 2, 0, 1, 1, 0, 0, 0, 0);
    chk("R10 chained space", g_done - g_acc, RO + 1 + 2*RY + 1 + RI + 1);
    chk("R12 space no word", g_cnt, 0);
    idle(2);
    run(2, 0, 0, 2, 0, 1, 1, 0, 0, 0, 0);
    chk("R10 other group not chained", g_first - g_acc, RO + RI + 1 + 2*RY + 1);
    idle(2 * CHAIN);
    run(2, 0, 0, 2, 0, 1, 1, 0, 0, 0, 0);
    chk("R10 window expired", g_first - g_acc, RO + RI + 1 + 2*RY + 1);
    idle(2 * CHAIN);

    // R3 write with gap at BOT
    run(2, 1, 1, 3, 0, 1, 1, 0, 0, 0, 0);
    chk("R3 gap first word", g_first - g_acc, RO + RB + 1 + GL*RY + 1 + 2*RY + 1);
    chk("R3 traverse seen", (g_mask >> 3) & 1, 1);
    chk("R7 write no error", g_fail, 0);
    chk("R4 write count", g_cnt, 3);
    idle(2 * CHAIN);

    // R6 read overrun
    run(0, 0, 0, 4, 0, 12, 1, 0, 0, 0, 0);
    chk("R6 overrun flag", g_terr, 1);
    chk("R6 record completes", g_cnt, 4);
    chk("R6 no fail", g_fail, 0);
    idle(2 * CHAIN);

    // R7 write underrun
    run(2, 0, 0, 3, 0, 1, 0, 0, 0, 0, 0);
    chk("R7 underrun flag", g_terr, 1);
    chk("R7 fail", g_fail, 1);
    chk("R7 no word", g_cnt, 0);
    chk("R7 error timing", g_done - g_acc, RO + RI + 1 + 2*RY + 1 + RI + 1);
    chk("R9 error phase seen", (g_mask >> 6) & 1, 1);
    idle(2 * CHAIN);

    // R8 fast read, slow channel: no overrun
    run(0, 0, 0, 4, 1, 15, 1, 0, 0, 0, 0);
    chk("R8 fast no error", g_terr, 0);
    chk("R8 fast count", g_cnt, 4);
    chk("R8 fast first word", g_first - g_acc, FO + FI + 1 + 2*FY + 1);
    idle(2 * CHAIN);

    // R8 R11 fast hold without strobe, then abort
    run(0, 0, 0, 4, 1, 1, 0, 0, 80, 0, 0);
    chk("R8 hold single word", g_cnt, 1);
    chk("R11 abort in hold", g_done - g_acc, 82);
    idle(2 * CHAIN);

    // R11 real abort in data
    s = RO + RI + 1 + 2*RY + 1 + 3;
    run(0, 0, 0, 6, 0, 1, 1, 0, s, 0, 0);
    chk("R11 abort done", g_done - g_acc, s + 2);
    chk("R11 abort words", g_cnt, 1);
    idle(2 * CHAIN);

    // R9 fault during write data
    run(2, 0, 0, 5, 0, 1, 1, 0, 0, s, 0);
    chk("R9 fault done", g_done - g_acc, s + 1 + RI + 1);
    chk("R9 fault fail", g_fail, 1);
    idle(2 * CHAIN);

    // R5 early channel end on read
    run(0, 0, 0, 6, 0, 1, 1, 2, 0, 0, 0);
    chk("R5 chan_end remainder", g_done - g_kcyc, 1 + (6 - 2) * RY + RI + 1);
    chk("R5 chan_end words", g_cnt, 2);
    chk("R5 chan_end eod", g_eod, 1);
    idle(2 * CHAIN);

    // R13 wait for channel go
    run(1, 0, 0, 2, 0, 1, 1, 0, 0, 0, 9);
    chk("R13 wait seen", (g_mask >> 1) & 1, 1);
    chk("R13 wait timing", g_first - g_acc, 9 + 1 + RO + RI + 1 + 2*RY + 1);
    idle(2 * CHAIN);

    // R12 rewind and select
    run(5, 0, 0, 1, 0, 1, 1, 0, 0, 0, 0);
    chk("R12 rewind", g_done - g_acc, RO + RI + 1 + RR + 1);
    run(6, 1, 0, 1, 0, 1, 1, 0, 0, 0, 0);
    chk("R12 select", g_done - g_acc, RO + 1 + 1);

    // random mix: R2 R4 R10 R12
    for (int k = 0; k < 40; k++) begin
      int op, bt, gp, ln, f;
      op = $urandom_range(0, 6); bt = $urandom_range(0, 1); gp = $urandom_range(0, 1);
      ln = $urandom_range(1, 5); f = $urandom_range(0, 1);
      idle($urandom_range(0, 40));
      run(op, bt, gp, ln, f, 1, 1, 0, 0, 0, 0);
      s = sdel(op, bt, g_chained, f);
      b = f ? FY : RY;
      if (op <= 2) begin
        chk("R2 random first word", g_first - g_acc,
            s + 1 + ((op == 2 && gp) ? GL*b + 1 : 0) + 2*b + 1);
        chk("R4 random count", g_cnt, ln);
        chk("R5 random stop", g_done - g_last, (f ? FI : RI) + 1);
        chk("R6 random no error", g_terr, 0);
      end else if (op <= 4) begin
        chk("R12 random space", g_done - g_acc, s + 1 + ln*b + 1 + (f ? FI : RI) + 1);
      end else if (op == 5) begin
        chk("R12 random rewind", g_done - g_acc, s + 1 + (f ? FR : RR) + 1);
      end else begin
        chk("R12 random select", g_done - g_acc, s + 2);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule